// File: doc/BRIEF.md
# Dual-Lane Serial I/Q Sample Deserializer

This block rebuilds parallel I/Q sample pairs from two single-bit serial lanes. One lane carries the in-phase samples and the other carries the quadrature samples. Both lanes share one bit clock and one strobe line. Every lane bit and the strobe are sampled on the rising edge of the bit clock. A low-to-high change of the sampled strobe marks the first bit of a word on both lanes. Each lane then shifts in the rest of the word, most significant bit first. When the last bit is in, the block presents both words together with a one-cycle valid flag.

Two static settings control the framing. The first selects the sample width: 16 bits or 12 bits. A 12-bit sample is left-justified into the 16-bit output, and its four lowest bits are zero. The second selects the strobe style. In pulse style the strobe is high for the first bit only. In level style the strobe is high for the first half of the word. The block checks the strobe shape in every bit of a word. Any departure from the selected style, and any new start edge that arrives before the word is complete, sets a sticky framing-error flag. A configuration change on the pins is taken up only at a start edge.

Top module: `iq_lane_deser`

## Requirements
- R1: Both lanes are sampled at each rising clock edge. At the edge where the sampled strobe changes from 0 to 1 (a start edge), the lane bits are the most significant bits of the new I and Q words. The following bits arrive in order from most significant to least significant, one per clock.
- R2: With `cfg_narrow`=0 a word is 16 bits long. With `cfg_narrow`=1 a word is 12 bits long.
- R3: A 12-bit sample appears in bits 15:4 of `i_word` and `q_word`, and bits 3:0 are 0. A 16-bit sample fills bits 15:0 unchanged.
- R4: `word_valid` is high for exactly one cycle, in the clock cycle right after the edge that captured the last bit. `i_word` and `q_word` change only at that point and hold their values until the next valid word.
- R5: Pulse style (`cfg_level`=0): the strobe must be low for bits 1 to N-1 of a word. A high strobe in any of those bits sets `frame_err`, and the word is still delivered if no start edge occurs.
- R6: Level style (`cfg_level`=1): the strobe must be high for bits 0 to N/2-1 and low for bits N/2 to N-1. Any mismatch sets `frame_err`, and the word is still delivered if no start edge occurs.
- R7: A start edge that arrives before the current word is complete drops the partial word without a valid output, starts a new word at that bit, and sets `frame_err`.
- R8: `frame_err` stays at 1 once it is set, until reset.
- R9: Reset clears `i_word`, `q_word`, `word_valid` and `frame_err` to 0. No word is produced until the first start edge after reset. A strobe that is already high when reset is released is not a start edge.
- R10: `cfg_narrow` and `cfg_level` are sampled only at a start edge. Changing them in the middle of a word does not change that word's length, strobe check or fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Shared framing strobe |
| lane_i | input | 1 | Serial in-phase data lane |
| lane_q | input | 1 | Serial quadrature data lane |
| cfg_narrow | input | 1 | 0: 16-bit samples, 1: 12-bit samples |
| cfg_level | input | 1 | 0: pulse strobe, 1: half-word level strobe |
| i_word | output | 16 | Last complete in-phase word |
| q_word | output | 16 | Last complete quadrature word |
| word_valid | output | 1 | One-cycle flag marking a new I/Q pair |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions assume that the clock is free-running, that all inputs are stable around each rising clock edge, and that the configuration pins are at valid 0/1 levels whenever a start edge happens. The bench changes every input only at falling clock edges. It sets the configuration pins in the same cycle as the strobe rises, except in the directed case that changes them in the middle of a word. Random traffic always keeps to a correct strobe shape for the selected style. Framing violations come only from directed cases, and each of those runs after its own reset so that the sticky flag can be observed for that case alone.

// File: rtl/iq_deser_pkg.sv
package iq_deser_pkg;

  typedef enum logic {
    WID_FULL   = 1'b0,
    WID_NARROW = 1'b1
  } width_sel_e;

  typedef enum logic {
    STB_PULSE = 1'b0,
    STB_LEVEL = 1'b1
  } stb_style_e;

  typedef struct packed {
    width_sel_e width;
    stb_style_e style;
  } deser_cfg_t;

endpackage

// File: rtl/iq_strobe_framer.sv
module iq_strobe_framer
  import iq_deser_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12,
  localparam int CNT_W   = $clog2(WORD_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  deser_cfg_t       cfg_in,
  output logic             start_evt,
  output logic             adv_evt,
  output logic             last_evt,
  output logic             busy,
  output logic [CNT_W-1:0] bit_cnt,
  output deser_cfg_t       act_cfg,
  output logic             err_evt,
  output logic             word_valid,
  output logic             frame_err
);

  // Number of bits in a word for a given width setting.
  function automatic logic [CNT_W-1:0] word_bits(input width_sel_e w);
    return (w == WID_NARROW) ? CNT_W'(NARROW_W) : CNT_W'(WORD_W);
  endfunction

  // Strobe level that a correct transmitter drives at bit index idx (idx >= 1).
  function automatic logic strobe_expect(input stb_style_e s,
                                         input logic [CNT_W-1:0] idx,
                                         input logic [CNT_W-1:0] nbits);
    return (s == STB_LEVEL) ? (idx < (nbits >> 1)) : 1'b0;
  endfunction

  logic             strb_prev;
  logic [CNT_W-1:0] act_bits;
  logic             shape_bad;

  assign act_bits  = word_bits(act_cfg.width);
  assign start_evt = strobe & ~strb_prev;
  assign adv_evt   = busy & ~start_evt;
  assign last_evt  = adv_evt & (bit_cnt == act_bits - CNT_W'(1));
  assign shape_bad = adv_evt & (strobe != strobe_expect(act_cfg.style, bit_cnt, act_bits));
  assign err_evt   = (busy & start_evt) | shape_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_prev  <= 1'b1;
      busy       <= 1'b0;
      bit_cnt    <= '0;
      act_cfg    <= '{width: WID_FULL, style: STB_PULSE};
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      strb_prev  <= strobe;
      word_valid <= last_evt;
      if (err_evt) frame_err <= 1'b1;
      if (start_evt) begin
        act_cfg <= cfg_in;
        busy    <= 1'b1;
        bit_cnt <= CNT_W'(1);
      end else if (last_evt) begin
        busy    <= 1'b0;
        bit_cnt <= '0;
      end else if (adv_evt) begin
        bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/iq_lane_shift.sv
module iq_lane_shift #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              start_evt,
  input  logic              adv_evt,
  input  logic              last_evt,
  input  logic              narrow,
  output logic [WORD_W-1:0] word
);

  localparam int PAD_W = WORD_W - NARROW_W;

  // Left-justify a narrow sample, zero-filling the low bits.
  function automatic logic [WORD_W-1:0] fill_word(input logic [WORD_W-1:0] raw,
                                                  input logic narrow_sel);
    return narrow_sel ? {raw[NARROW_W-1:0], {PAD_W{1'b0}}} : raw;
  endfunction

  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_next;

  assign sh_next = {sh[WORD_W-2:0], din};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      word <= '0;
    end else begin
      if (start_evt)     sh <= {{(WORD_W-1){1'b0}}, din};
      else if (adv_evt)  sh <= sh_next;
      if (last_evt) word <= fill_word(sh_next, narrow);
    end
  end

endmodule

// File: rtl/iq_lane_deser.sv
module iq_lane_deser
  import iq_deser_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              lane_i,
  input  logic              lane_q,
  input  logic              cfg_narrow,
  input  logic              cfg_level,
  output logic [WORD_W-1:0] i_word,
  output logic [WORD_W-1:0] q_word,
  output logic              word_valid,
  output logic              frame_err
);

  localparam int CNT_W   = $clog2(WORD_W) + 1;
  localparam int N_LANES = 2;

  deser_cfg_t       cfg_pins;
  deser_cfg_t       act_cfg;
  logic             start_evt;
  logic             adv_evt;
  logic             last_evt;
  logic             busy;
  logic             err_evt;
  logic             act_narrow;
  logic             act_level;
  logic [CNT_W-1:0] bit_cnt;
  logic [N_LANES-1:0]           lane_bits;
  logic [N_LANES-1:0][WORD_W-1:0] lane_words;

  assign cfg_pins   = '{width: width_sel_e'(cfg_narrow), style: stb_style_e'(cfg_level)};
  assign act_narrow = (act_cfg.width == WID_NARROW);
  assign act_level  = (act_cfg.style == STB_LEVEL);
  assign lane_bits  = {lane_q, lane_i};

  iq_strobe_framer #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .cfg_in     (cfg_pins),
    .start_evt  (start_evt),
    .adv_evt    (adv_evt),
    .last_evt   (last_evt),
    .busy       (busy),
    .bit_cnt    (bit_cnt),
    .act_cfg    (act_cfg),
    .err_evt    (err_evt),
    .word_valid (word_valid),
    .frame_err  (frame_err)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    iq_lane_shift #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (lane_bits[g]),
      .start_evt (start_evt),
      .adv_evt   (adv_evt),
      .last_evt  (last_evt),
      .narrow    (act_narrow),
      .word      (lane_words[g])
    );
  end

  assign i_word = lane_words[0];
  assign q_word = lane_words[1];

endmodule

// File: rtl/iq_lane_deser_chk.sv
module iq_lane_deser_chk #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12,
  localparam int CNT_W   = $clog2(WORD_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_valid,
  input logic              frame_err,
  input logic [WORD_W-1:0] i_word,
  input logic [WORD_W-1:0] q_word,
  input logic              start_evt,
  input logic              busy,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              act_narrow,
  input logic              act_level
);

  localparam int PAD_W = WORD_W - NARROW_W;

  logic seen_start;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_start <= 1'b0;
    else if (start_evt) seen_start <= 1'b1;
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R8

  AST_NO_VALID_BEFORE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> seen_start); // R9

  AST_EARLY_EDGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_evt) |=> frame_err); // R7

  AST_NARROW_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && act_narrow) |-> (i_word[PAD_W-1:0] == '0 && q_word[PAD_W-1:0] == '0)); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(bit_cnt) < (act_narrow ? NARROW_W : WORD_W))); // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> ($stable(act_narrow) && $stable(act_level))); // R10

endmodule

bind iq_lane_deser iq_lane_deser_chk #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_valid (word_valid),
  .frame_err  (frame_err),
  .i_word     (i_word),
  .q_word     (q_word),
  .start_evt  (start_evt),
  .busy       (busy),
  .bit_cnt    (bit_cnt),
  .act_narrow (act_narrow),
  .act_level  (act_level)
);

// File: tb/iq_lane_deser_test.sv
module iq_lane_deser_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic        lane_i = 1'b0;
  logic        lane_q = 1'b0;
  logic        cfg_narrow = 1'b0;
  logic        cfg_level = 1'b0;
  logic [15:0] i_word;
  logic [15:0] q_word;
  logic        word_valid;
  logic        frame_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_valid = 0;
  bit done = 1'b0;

  logic [15:0] exp_i[$];
  logic [15:0] exp_q[$];
  int          exp_c[$];
  string       exp_tag[$];
  logic [15:0] last_i = '0;
  logic [15:0] last_q = '0;

  iq_lane_deser uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .lane_i     (lane_i),
    .lane_q     (lane_q),
    .cfg_narrow (cfg_narrow),
    .cfg_level  (cfg_level),
    .i_word     (i_word),
    .q_word     (q_word),
    .word_valid (word_valid),
    .frame_err  (frame_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Expected parallel word from a raw sample.
  function automatic logic [15:0] exp_word(input logic [15:0] raw, input bit nar);
    logic [15:0] r;
    r = raw;
    if (nar) r = {raw[11:0], 4'h0};
    return r;
  endfunction

  // Strobe a correct transmitter drives on bit b of an n-bit word.
  function automatic bit good_strobe(input int b, input int n, input bit lvl);
    if (b == 0) return 1'b1;
    if (lvl) return (b < n / 2);
    return 1'b0;
  endfunction

  // Output monitor: checks every valid word against the expected queue.
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      n_valid++;
      if (exp_i.size() == 0) begin
        chk(1'b0, "R4 unexpected valid", {16'h0, i_word}, 32'h0);
      end else begin
        logic [15:0] ei;
        logic [15:0] eq;
        int          ec;
        string       t;
        ei = exp_i.pop_front();
        eq = exp_q.pop_front();
        ec = exp_c.pop_front();
        t  = exp_tag.pop_front();
        chk(i_word == ei, {t, " i_word"}, {16'h0, i_word}, {16'h0, ei});
        chk(q_word == eq, {t, " q_word"}, {16'h0, q_word}, {16'h0, eq});
        chk(cyc == ec, {t, " R4 valid cycle"}, cyc, ec);
        last_i = ei;
        last_q = eq;
      end
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      strobe = 1'b0;
      lane_i = 1'($urandom);
      lane_q = 1'($urandom);
    end
  endtask

  // mode: 0 good, 1 bad strobe shape, 2 flip config pins at bit 3
  // nbits_sent < word length gives a partial word (no expectation pushed)
  task automatic send_word(input logic [15:0] iv, input logic [15:0] qv,
                           input bit nar, input bit lvl, input int mode,
                           input int nbits_sent, input string tag);
    int n;
    n = nar ? 12 : 16;
    for (int b = 0; b < nbits_sent; b++) begin
      @(negedge clk);
      strobe = good_strobe(b, n, lvl);
      if (mode == 1) begin
        if (lvl && b >= 2 && b < n / 2) strobe = 1'b0;
        if (!lvl && b == 1) strobe = 1'b1;
      end
      if (b == 0) begin
        cfg_narrow = nar;
        cfg_level  = lvl;
      end
      if (mode == 2 && b == 3) begin
        cfg_narrow = ~nar;
        cfg_level  = ~lvl;
      end
      lane_i = iv[n-1-b];
      lane_q = qv[n-1-b];
    end
    if (nbits_sent == n) begin
      exp_i.push_back(exp_word(iv, nar));
      exp_q.push_back(exp_word(qv, nar));
      exp_c.push_back(cyc + 1);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic do_reset(input bit stb);
    @(negedge clk);
    rst_n  = 1'b0;
    strobe = stb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain(input string tag);
    idle(4);
    chk(exp_i.size() == 0, {tag, " R4 missing valid"}, exp_i.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nv;
    void'($urandom(32'h5EED_1234));

    // R9: reset with strobe held high through release
    do_reset(1'b1);
    @(negedge clk);
    chk(word_valid == 1'b0, "R9 reset valid", word_valid, 0);
    chk(frame_err == 1'b0, "R9 reset frame_err", frame_err, 0);
    chk(i_word == 16'h0 && q_word == 16'h0, "R9 reset words", {i_word, q_word}, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      strobe = 1'b1;
      lane_i = 1'($urandom);
      lane_q = 1'($urandom);
    end
    @(negedge clk);
    chk(n_valid == 0, "R9 no word without start edge", n_valid, 0);
    chk(frame_err == 1'b0, "R9 no error without start edge", frame_err, 0);
    idle(1);

    // R1 R2: 16-bit pulse style, MSB first
    send_word(16'hA5C3, 16'h1234, 1'b0, 1'b0, 0, 16, "R1 R5 full pulse");
    drain("R1");
    // R4: words hold after valid
    chk(i_word == 16'hA5C3 && q_word == 16'h1234, "R4 hold after valid", {i_word, q_word}, {16'hA5C3, 16'h1234});
    // R6: 16-bit level style
    send_word(16'h8001, 16'h7FFE, 1'b0, 1'b1, 0, 16, "R6 full level");
    // R3: 12-bit pulse and level, back to back
    send_word(16'h0ABC, 16'h0F0F, 1'b1, 1'b0, 0, 12, "R3 narrow pulse");
    send_word(16'h0FFF, 16'h0801, 1'b1, 1'b1, 0, 12, "R3 R2 narrow level");
    drain("R3");
    chk(frame_err == 1'b0, "R5 R6 clean framing no error", frame_err, 0);

    // R10: config pins flip mid-word
    send_word(16'hBEEF, 16'hCAFE, 1'b0, 1'b1, 2, 16, "R10 full cfg flip");
    send_word(16'h0123, 16'h0456, 1'b1, 1'b0, 2, 12, "R10 narrow cfg flip");
    drain("R10");
    chk(frame_err == 1'b0, "R10 flip causes no error", frame_err, 0);

    // R7: early start edge in pulse style
    do_reset(1'b0);
    idle(2);
    nv = n_valid;
    send_word(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 0, 6, "R7 partial");
    chk(frame_err == 1'b0, "R7 no error before early edge", frame_err, 0);
    send_word(16'h3C3C, 16'hC3C3, 1'b0, 1'b0, 0, 16, "R7 restart pulse");
    drain("R7");
    chk(n_valid == nv + 1, "R7 partial word dropped", n_valid, nv + 1);
    chk(frame_err == 1'b1, "R7 early edge error", frame_err, 1);
    // R8: error stays set through good words
    send_word(16'h1111, 16'h2222, 1'b0, 1'b0, 0, 16, "R8 after error");
    drain("R8");
    chk(frame_err == 1'b1, "R8 sticky error", frame_err, 1);

    // R7: early start edge in level style (after strobe has fallen)
    do_reset(1'b0);
    idle(2);
    nv = n_valid;
    send_word(16'h0000, 16'h0000, 1'b0, 1'b1, 0, 10, "R7 partial level");
    send_word(16'h0555, 16'h0AAA, 1'b1, 1'b1, 0, 12, "R7 restart level");
    drain("R7 level");
    chk(n_valid == nv + 1, "R7 level partial dropped", n_valid, nv + 1);
    chk(frame_err == 1'b1, "R7 level early edge error", frame_err, 1);

    // R6: level strobe falls too soon
    do_reset(1'b0);
    idle(2);
    send_word(16'h9876, 16'h5432, 1'b0, 1'b1, 1, 16, "R6 bad shape delivered");
    drain("R6");
    chk(frame_err == 1'b1, "R6 shape error", frame_err, 1);

    // R5: pulse strobe stays high two bits
    do_reset(1'b0);
    idle(2);
    send_word(16'h0321, 16'h0654, 1'b1, 1'b0, 1, 12, "R5 bad shape delivered");
    drain("R5");
    chk(frame_err == 1'b1, "R5 shape error", frame_err, 1);

    // Random traffic with correct framing
    do_reset(1'b0);
    idle(2);
    for (int w = 0; w < 300; w++) begin
      bit          nar;
      bit          lvl;
      logic [15:0] iv;
      logic [15:0] qv;
      nar = 1'($urandom);
      lvl = 1'($urandom);
      iv  = 16'($urandom);
      qv  = 16'($urandom);
      if (nar) begin
        iv[15:12] = 4'h0;
        qv[15:12] = 4'h0;
      end
      send_word(iv, qv, nar, lvl, 0, nar ? 12 : 16, nar ? "R3 R2 random" : "R1 R2 random");
      if ($urandom_range(3) == 0) idle(int'($urandom_range(3)) + 1);
    end
    drain("R4 random");
    chk(frame_err == 1'b0, "R5 R6 random no error", frame_err, 0);
    idle(3);
    chk(i_word == last_i && q_word == last_q, "R4 hold in idle", {i_word, q_word}, {last_i, last_q});

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule